// File: doc/BRIEF.md
# Fourth-Order Sinc Decimator

This block turns the one-bit pulse stream of a sigma-delta modulator into signed conversion words. The density of ones in the stream carries the signal. Each accepted bit is mapped to +1 or -1 and fed into four cascaded accumulators running at the bit rate. After every DECIM accepted bits, the accumulator total is passed through four cascaded first differences running at the word rate. The combined response is a (sin x / x)^4 low-pass whose first notch sits at the word rate, with further notches at its integer multiples. All timing counts accepted bits, so a slower modulator clock gives a proportionally slower word rate.

The response of a fourth-order filter takes four word periods to settle. Each word therefore carries a settled flag, which stays low for the first three words after reset or after a synchronous restart. The datapath has room for the full ±DECIM^4 swing. Nominal full scale is four fifths of that swing, which leaves 25% headroom above it. Words beyond nominal full scale in either direction raise an over or under flag. A controller applies restart after an input step, or whenever it needs a fresh settling sequence.

Top module: `sinc4_decim`

## Requirements
- R1: A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. An unbroken stream of ones gives words that reach +DECIM^4 once settled, and an unbroken stream of zeros gives -DECIM^4.
- R2: The word produced after the k-th group of DECIM accepted bits equals the sum over j of h[j]·x[k·DECIM−j]. Here h is four length-DECIM boxcars convolved together (4·DECIM−3 taps), and x counts as 0 before reset or restart.
- R3: A bit is accepted only in a cycle where the bit strobe is high. Bits offered with the strobe low change nothing. The valid output is a one-cycle pulse in the cycle after every DECIM-th accepted bit.
- R4: The settled flag is low for the first three words after reset or restart. It rises together with the fourth word and then stays high.
- R5: The over flag is high exactly while the held word is greater than nominal full scale, floor(DECIM^4·4/5).
- R6: The under flag is high exactly while the held word is less than the negative of nominal full scale.
- R7: A synchronous restart, which takes priority over the bit strobe, clears the accumulators, the differences, the bit count, the word count, the result and the flags.
- R8: In the cycle after reset the result is zero and valid, settled, over and under are all low.
- R9: The result is held unchanged between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous clear of all filter state |
| mod_bit | input | 1 | Modulator output bit |
| mod_vld | input | 1 | Bit strobe; high when mod_bit is to be accepted |
| result_o | output | 2+4·clog2(DECIM) | Signed conversion word |
| valid_o | output | 1 | One-cycle pulse marking a new word |
| settled_o | output | 1 | Word is past the four-period settling time |
| over_o | output | 1 | Word above nominal full scale |
| under_o | output | 1 | Word below negative nominal full scale |

## Verification
A single wrong accumulator or difference register shows up as a mismatch in the next conversion word. Because the error does not decay, it then stays wrong in every later word until a restart. A miscounted bit position shifts the valid pulse by a cycle and changes the sum, so the very next word exposes it. The reference model recomputes every word from the raw accepted bits, using the convolved coefficient set. Every port is compared on every clock, so a fault shows up within one word period.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

    localparam int ORDER = 4;

    function automatic int acc_width(input int decim);
        return 2 + ORDER * $clog2(decim);
    endfunction

    function automatic longint nominal_fs(input int decim);
        longint peak;
        peak = longint'(decim) * decim * decim * decim;
        return (peak * 4) / 5;
    endfunction

    typedef struct packed {
        logic settled;
        logic over;
        logic under;
    } word_flags_t;

endpackage

// File: rtl/sinc4_integ.sv
module sinc4_integ
    import sinc4_pkg::*;
#(
    parameter int DECIM = 64,
    parameter int W     = 26
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                mod_bit,
    input  logic                mod_vld,
    output logic signed [W-1:0] sample_o,
    output logic                tick_o
);
    localparam int CW = $clog2(DECIM);

    logic signed [W-1:0] acc_q [ORDER];
    logic signed [W-1:0] nxt   [ORDER+1];
    logic [CW-1:0]       cnt_q;

    assign nxt[0] = mod_bit ? W'(1) : '1;

    for (genvar s = 0; s < ORDER; s++) begin : g_stage
        assign nxt[s+1] = acc_q[s] + nxt[s];

        always_ff @(posedge clk) begin
            if (rst || restart) begin
                acc_q[s] <= '0;
            end else if (mod_vld) begin
                acc_q[s] <= nxt[s+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (mod_vld) begin
            cnt_q <= (cnt_q == CW'(DECIM - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_o   = mod_vld && !restart && (cnt_q == CW'(DECIM - 1));
    assign sample_o = nxt[ORDER];

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restart) && !$past(mod_vld)) |-> $stable(acc_q[0])); // R3
endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb
    import sinc4_pkg::*;
#(
    parameter int W = 26
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                tick_i,
    input  logic signed [W-1:0] sample_i,
    output logic signed [W-1:0] result_o,
    output logic                valid_o
);
    logic signed [W-1:0] prev_q [ORDER];
    logic signed [W-1:0] diff   [ORDER+1];

    assign diff[0] = sample_i;

    for (genvar s = 0; s < ORDER; s++) begin : g_diff
        assign diff[s+1] = diff[s] - prev_q[s];

        always_ff @(posedge clk) begin
            if (rst || restart) begin
                prev_q[s] <= '0;
            end else if (tick_i) begin
                prev_q[s] <= diff[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= tick_i;
            if (tick_i) begin
                result_o <= diff[ORDER];
            end
        end
    end

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restart) && !valid_o) |-> $stable(result_o)); // R9
endmodule

// File: rtl/sinc4_settle.sv
module sinc4_settle
    import sinc4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick_i,
    output logic settled_o
);
    localparam int SW = $clog2(ORDER);

    logic [SW-1:0] words_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            words_q   <= '0;
            settled_o <= 1'b0;
        end else if (tick_i) begin
            if (words_q < SW'(ORDER - 1)) begin
                words_q <= words_q + 1'b1;
            end else begin
                settled_o <= 1'b1;
            end
        end
    end

    AST_SETTLE_ON_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(settled_o) |-> $past(tick_i)); // R4
endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim
    import sinc4_pkg::*;
#(
    parameter  int DECIM = 64,
    localparam int W     = acc_width(DECIM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                mod_bit,
    input  logic                mod_vld,
    output logic signed [W-1:0] result_o,
    output logic                valid_o,
    output logic                settled_o,
    output logic                over_o,
    output logic                under_o
);
    localparam logic signed [W-1:0] FS_POS = W'(nominal_fs(DECIM));
    localparam logic signed [W-1:0] FS_NEG = -FS_POS;

    logic signed [W-1:0] sample;
    logic                tick;
    word_flags_t         flags;

    sinc4_integ #(.DECIM(DECIM), .W(W)) u_integ (
        .clk(clk), .rst(rst), .restart(restart),
        .mod_bit(mod_bit), .mod_vld(mod_vld),
        .sample_o(sample), .tick_o(tick)
    );

    sinc4_comb #(.W(W)) u_comb (
        .clk(clk), .rst(rst), .restart(restart),
        .tick_i(tick), .sample_i(sample),
        .result_o(result_o), .valid_o(valid_o)
    );

    sinc4_settle u_settle (
        .clk(clk), .rst(rst), .restart(restart),
        .tick_i(tick), .settled_o(flags.settled)
    );

    assign flags.over  = result_o > FS_POS;
    assign flags.under = result_o < FS_NEG;

    assign settled_o = flags.settled;
    assign over_o    = flags.over;
    assign under_o   = flags.under;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R3

    AST_RANGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(over_o && under_o)); // R5 R6

    AST_RESTART_CLR: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> (result_o == '0 && !valid_o && !settled_o)); // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (result_o == '0 && !valid_o && !settled_o && !over_o && !under_o)); // R8
endmodule

// File: tb/sinc4_decim_tb_top.sv
module sinc4_decim_tb_top;
    localparam int N    = 8;
    localparam int W    = 2 + 4 * 3;
    localparam int TAPS = 4 * N - 3;
    localparam int FS   = (N * N * N * N * 4) / 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic restart = 1'b0;
    logic mod_bit = 1'b0;
    logic mod_vld = 1'b0;
    logic signed [W-1:0] result_o;
    logic valid_o, settled_o, over_o, under_o;

    int checks = 0;
    int errors = 0;
    int h [0:4*N-1];
    int hist [$];
    int bitcnt = 0;
    int words = 0;
    int exp_res = 0;
    bit exp_vld = 0;
    bit exp_set = 0;
    string res_tag = "R2";

    always #4 clk = ~clk;

    sinc4_decim #(.DECIM(N)) dut_i (
        .clk(clk), .rst(rst), .restart(restart),
        .mod_bit(mod_bit), .mod_vld(mod_vld),
        .result_o(result_o), .valid_o(valid_o), .settled_o(settled_o),
        .over_o(over_o), .under_o(under_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        hist.delete();
        bitcnt = 0; words = 0; exp_res = 0; exp_vld = 0; exp_set = 0;
    endtask

    task automatic model_step(input logic b, input logic v, input logic rs);
        int y;
        exp_vld = 0;
        if (rs) begin
            model_clear();
        end else if (v) begin
            hist.push_back(b ? 1 : -1);
            bitcnt++;
            if (bitcnt == N) begin
                bitcnt = 0;
                y = 0;
                for (int j = 0; j < TAPS && j < hist.size(); j++)
                    y += h[j] * hist[hist.size() - 1 - j];
                exp_res = y;
                words++;
                exp_vld = 1;
                exp_set = (words >= 4);
            end
        end
    endtask

    task automatic compare_all();
        check("R3 valid", int'(valid_o), int'(exp_vld));
        check(exp_vld ? res_tag : "R9", int'(result_o), exp_res);
        check("R4 settled", int'(settled_o), int'(exp_set));
        check("R5 over", int'(over_o), int'(exp_res > FS));
        check("R6 under", int'(under_o), int'(exp_res < -FS));
    endtask

    task automatic step(input logic b, input logic v, input logic rs);
        @(negedge clk);
        mod_bit = b; mod_vld = v; restart = rs;
        @(posedge clk);
        #2;
        model_step(b, v, rs);
        compare_all();
    endtask

    initial begin
        int t [0:4*N-1];
        int len;
        for (int i = 0; i < 4 * N; i++) h[i] = 0;
        h[0] = 1;
        len = 1;
        repeat (4) begin
            for (int i = 0; i < 4 * N; i++) t[i] = 0;
            for (int i = 0; i < len; i++)
                for (int k = 0; k < N; k++) t[i+k] += h[i];
            len += N - 1;
            for (int i = 0; i < 4 * N; i++) h[i] = t[i];
        end

        repeat (3) @(posedge clk);
        #2;
        // R8 reset state
        check("R8 result", int'(result_o), 0);
        check("R8 valid", int'(valid_o), 0);
        check("R8 settled", int'(settled_o), 0);
        check("R8 flags", int'(over_o) + int'(under_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: irregular bit pattern with gaps in the strobe
        res_tag = "R2";
        repeat (N * 8) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), 1'b0);

        // R3: strobe low, toggling bits must change nothing
        for (int i = 0; i < 3 * N; i++) step(1'(i[0]), 1'b0, 1'b0);

        // R1: all ones, then all zeros, to the full peaks
        res_tag = "R1";
        repeat (N * 8) step(1'b1, 1'b1, 1'b0);
        check("R1 peak pos", exp_res, N * N * N * N);
        repeat (N * 8) step(1'b0, 1'b1, 1'b0);
        check("R1 peak neg", exp_res, -(N * N * N * N));

        // R2: alternating pattern gives a midscale word
        res_tag = "R2";
        for (int i = 0; i < N * 8; i++) step(1'(i[0]), 1'b1, 1'b0);

        // R7: restart partway through a word, with the strobe high
        res_tag = "R7";
        repeat (3) step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        repeat (N * 6) step(1'($urandom_range(0, 1)), 1'b1, 1'b0);

        // R5 R6: mostly ones, then mostly zeros, near the limits
        res_tag = "R2";
        for (int i = 0; i < N * 8; i++) step(1'((i % 10) != 0), 1'b1, 1'b0);
        for (int i = 0; i < N * 8; i++) step(1'((i % 10) == 0), 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule